// File: doc/BRIEF.md
# Memory-Type-Aware Ordering Write Buffer

This block sits between a processor's load/store port and one downstream bus. Every request from the core is classified on arrival against a small programmable region table. The table gives each address one of three memory types: Normal, Device or Strongly-ordered. It also gives a shareable flag and an execute-never flag. From that classification the block decides what to do with the request:

- post a write into a four-entry buffer and acknowledge it at once;
- hold the request until older buffered writes have drained;
- send it straight to the bus, ahead of buffered writes where the rules allow.

An instruction fetch that lands in an execute-never region never reaches the bus. The core gets an error response for it. The block also raises a one-cycle fault pulse and latches the offending address.

The core side and the bus side both use a valid/ready handshake. The bus completes a transfer in the cycle it accepts it, and returns read data in that same cycle. The core always takes the response, which arrives one cycle after the request is accepted. The region table is loaded through a simple write port, one entry per cycle.

Top module: `mt_order_wbuf`

## Requirements
- R1: Each address is classified by the highest-numbered table entry whose inclusive range (low bound ≤ address ≤ high bound) contains it. The type code is 00 Normal, 01 Device, 10 Strongly-ordered, and 11 is treated as Strongly-ordered. An address that no entry covers is Normal, shareable and executable. After reset no entry covers any address.
- R2: The shareable attribute is reported on `resp_shr` and `bus_shr`. It is forced to 1 for every Strongly-ordered access, whatever the programmed flag says.
- R3: A Normal or Device write is accepted in the same cycle it is presented, provided the buffer has room, even with `bus_ready` low. Its response follows one cycle later. The buffer holds 4 writes, and with 4 held a further such write sees `req_ready` low.
- R4: Buffered writes reach the bus in the order they were accepted, with their address, data and shareable flag.
- R5: A Strongly-ordered write is never buffered. It is presented to the bus only once the buffer is empty, and the core is held until the bus accepts it.
- R6: A Device or Strongly-ordered read, including a fetch, reaches the bus only after every buffered write has drained.
- R7: A Normal read whose address equals no buffered write is sent to the bus ahead of the buffered writes.
- R8: A Normal read whose address equals a buffered write waits until that write has drained. It then returns the newly written data.
- R9: A fetch from an execute-never region is accepted at once and not sent to the bus. One cycle later the block gives an error response, a single-cycle `fault_pulse`, and `fault_addr` equal to the fetch address. A data read from the same region is served normally.
- R10: After reset the block holds `resp_valid`, `fault_pulse` and `bus_valid` low and `fault_addr` at zero.
- R11: Read data is the bus data sampled in the accepting cycle, presented on `resp_rdata` with the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one region-table entry |
| cfg_idx | input | IW | Entry number being written |
| cfg_base | input | AW | Low bound of the range, inclusive |
| cfg_limit | input | AW | High bound of the range, inclusive |
| cfg_type | input | 2 | Memory type code |
| cfg_shr | input | 1 | Shareable flag |
| cfg_xn | input | 1 | Execute-never flag |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted this cycle |
| req_write | input | 1 | Request is a write |
| req_fetch | input | 1 | Request is an instruction fetch (always a read) |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_err | output | 1 | Response is an error |
| resp_shr | output | 1 | Shareable attribute of the answered access |
| resp_rdata | output | DW | Read data |
| bus_valid | output | 1 | Bus transfer valid |
| bus_ready | input | 1 | Bus accepts the transfer |
| bus_write | output | 1 | Bus transfer is a write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_shr | output | 1 | Bus shareable attribute |
| bus_rdata | input | DW | Bus read data, valid with the handshake |
| fault_pulse | output | 1 | Execute-never fetch fault |
| fault_addr | output | AW | Address of the last faulting fetch |

## Verification
The hardest states to reach from the ports are those where a read meets writes still sitting in the buffer. This matters most for a Normal read to the same address as a buffered write, or one that should bypass them. The bench reaches these states by holding `bus_ready` low while it posts writes, then presenting the read, and only then opening the bus. The order in which transfers appear on the bus shows whether the read bypassed, waited, or drained first. The data a same-address read returns shows that it saw the newest write. Region classification is swept over every address of an 8-bit space, as both fetches and data reads, against a table with overlapping, empty and reserved-code entries.

// File: rtl/mtob_pkg.sv
// Shared types for the ordering write buffer.
// Assumes nothing beyond a 2-bit type code per region.
package mtob_pkg;
    typedef enum logic [1:0] {
        MT_NORMAL   = 2'b00,
        MT_DEVICE   = 2'b01,
        MT_STRONG   = 2'b10,
        MT_RESERVED = 2'b11
    } mem_type_e;

    typedef struct packed {
        mem_type_e mtype;
        logic      shr;
        logic      xn;
    } region_attr_t;
endpackage

// File: rtl/mtob_region_table.sv
// Programmable region table with a combinational lookup.
// Each entry holds an inclusive address range and attributes.
// Where entries overlap, the highest-numbered match wins. An unmatched
// address is Normal, shareable and executable. The output is normalised:
// the reserved code reads as Strongly-ordered, which is always shareable.
// Assumes: NREG is a power of two; cfg writes take effect next cycle.
module mtob_region_table
    import mtob_pkg::*;
#(
    parameter  int AW   = 16,
    parameter  int NREG = 8,
    localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IW-1:0]      cfg_idx,
    input  logic [AW-1:0]      cfg_base,
    input  logic [AW-1:0]      cfg_limit,
    input  logic [1:0]         cfg_type,
    input  logic               cfg_shr,
    input  logic               cfg_xn,
    input  logic [AW-1:0]      look_addr,
    output region_attr_t       look_attr
);
    logic [AW-1:0] base_q  [NREG];
    logic [AW-1:0] limit_q [NREG];
    mem_type_e     type_q  [NREG];
    logic          shr_q   [NREG];
    logic          xn_q    [NREG];
    logic [NREG-1:0] match;
    region_attr_t    raw;

    // Entry storage: reset makes every range empty (low > high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                base_q[i]  <= '1;
                limit_q[i] <= '0;
                type_q[i]  <= MT_NORMAL;
                shr_q[i]   <= 1'b0;
                xn_q[i]    <= 1'b0;
            end
        end else if (cfg_we) begin
            base_q[cfg_idx]  <= cfg_base;
            limit_q[cfg_idx] <= cfg_limit;
            type_q[cfg_idx]  <= mem_type_e'(cfg_type);
            shr_q[cfg_idx]   <= cfg_shr;
            xn_q[cfg_idx]    <= cfg_xn;
        end
    end

    // One range comparator per entry.
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign match[g] = (look_addr >= base_q[g]) && (look_addr <= limit_q[g]);
    end

    // Priority pick: later (higher) entries override earlier ones.
    always_comb begin
        raw = '{mtype: MT_NORMAL, shr: 1'b1, xn: 1'b0};
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) begin
                raw = '{mtype: type_q[i], shr: shr_q[i], xn: xn_q[i]};
            end
        end
    end

    // Normalise the reserved code and the shareable rule.
    always_comb begin
        look_attr       = raw;
        if (raw.mtype == MT_RESERVED) begin
            look_attr.mtype = MT_STRONG;
        end
        look_attr.shr = raw.shr || (look_attr.mtype == MT_STRONG);
    end
endmodule

// File: rtl/mtob_post_fifo.sv
// In-order buffer of posted writes with an address probe.
// Reports whether any held write matches a given address exactly.
// Assumes: DEPTH is a power of two, at least 2; push only when not full,
// pop only when not empty.
module mtob_post_fifo #(
    parameter  int AW    = 16,
    parameter  int DW    = 32,
    parameter  int DEPTH = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          push_shr,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          head_shr,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit
);
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic             shr_q  [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] hit_vec;
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    fill_q;

    // Pointer, occupancy and slot-valid bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
            vld_q  <= '0;
        end else begin
            if (push) begin
                vld_q[wr_ptr] <= 1'b1;
                wr_ptr        <= wr_ptr + 1'b1;
            end
            if (pop) begin
                vld_q[rd_ptr] <= 1'b0;
                rd_ptr        <= rd_ptr + 1'b1;
            end
            fill_q <= fill_q + CW'(push) - CW'(pop);
        end
    end

    // Payload storage, written on push only.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
            shr_q[wr_ptr]  <= push_shr;
        end
    end

    // Per-slot address comparators for the read-after-write probe.
    for (genvar g = 0; g < DEPTH; g++) begin : g_probe
        assign hit_vec[g] = vld_q[g] && (addr_q[g] == probe_addr);
    end

    assign probe_hit = |hit_vec;
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign head_shr  = shr_q[rd_ptr];
    assign fill      = fill_q;
    assign full      = (fill_q == CW'(DEPTH));
    assign empty     = (fill_q == '0);
endmodule

// File: rtl/mt_order_wbuf.sv
// Ordering write buffer between a core load/store port and one bus.
// Classifies each request by region. It then posts, holds or issues the
// request directly, following these rules:
// - Normal/Device writes are posted.
// - Strongly-ordered writes and all Device/Strongly-ordered reads wait for
//   the buffer to empty.
// - Normal reads bypass buffered writes unless one has the same address.
// - Execute-never fetches fault without touching the bus.
// Assumes: the bus completes a transfer in its handshake cycle, with read
// data valid then; the core always accepts the response.
module mt_order_wbuf
    import mtob_pkg::*;
#(
    parameter  int AW    = 16,
    parameter  int DW    = 32,
    parameter  int NREG  = 8,
    parameter  int DEPTH = 4,
    localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic [1:0]    cfg_type,
    input  logic          cfg_shr,
    input  logic          cfg_xn,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_fetch,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          resp_valid,
    output logic          resp_err,
    output logic          resp_shr,
    output logic [DW-1:0] resp_rdata,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_shr,
    input  logic [DW-1:0] bus_rdata,
    output logic          fault_pulse,
    output logic [AW-1:0] fault_addr
);
    region_attr_t  attr;
    mem_type_e     hit_type;
    logic          hit_shr;
    logic          hit_xn;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic          head_shr;
    logic [CW-1:0] fifo_fill;
    logic          fifo_full;
    logic          fifo_empty;
    logic          fifo_hit;
    logic          is_wr;
    logic          xn_fault;
    logic          post_ok;
    logic          direct_ok;
    logic          core_bus;
    logic          accept;
    logic          push;
    logic          pop;

    mtob_region_table #(.AW(AW), .NREG(NREG)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_base  (cfg_base),
        .cfg_limit (cfg_limit),
        .cfg_type  (cfg_type),
        .cfg_shr   (cfg_shr),
        .cfg_xn    (cfg_xn),
        .look_addr (req_addr),
        .look_attr (attr)
    );

    assign hit_type = attr.mtype;
    assign hit_shr  = attr.shr;
    assign hit_xn   = attr.xn;

    mtob_post_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_addr  (req_addr),
        .push_data  (req_wdata),
        .push_shr   (hit_shr),
        .pop        (pop),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .head_shr   (head_shr),
        .fill       (fifo_fill),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .probe_addr (req_addr),
        .probe_hit  (fifo_hit)
    );

    // Request decode: a fetch is always a read.
    assign is_wr    = req_write && !req_fetch;
    assign xn_fault = req_fetch && hit_xn;
    assign post_ok  = is_wr && (hit_type != MT_STRONG) && !fifo_full;

    // Ordering decision for requests that go straight to the bus.
    always_comb begin
        if (xn_fault) begin
            direct_ok = 1'b0;
        end else if (is_wr) begin
            direct_ok = (hit_type == MT_STRONG) && fifo_empty;
        end else if (hit_type == MT_NORMAL) begin
            direct_ok = !fifo_hit;
        end else begin
            direct_ok = fifo_empty;
        end
    end

    assign core_bus  = req_valid && direct_ok;
    assign req_ready = xn_fault || post_ok || (direct_ok && bus_ready);
    assign accept    = req_valid && req_ready;
    assign push      = req_valid && post_ok;
    assign pop       = !core_bus && !fifo_empty && bus_ready;

    // Bus mux: a direct core access has priority over draining.
    always_comb begin
        if (core_bus) begin
            bus_valid = 1'b1;
            bus_write = is_wr;
            bus_addr  = req_addr;
            bus_wdata = is_wr ? req_wdata : '0;
            bus_shr   = hit_shr;
        end else begin
            bus_valid = !fifo_empty;
            bus_write = 1'b1;
            bus_addr  = head_addr;
            bus_wdata = head_data;
            bus_shr   = head_shr;
        end
    end

    // Core response and fault reporting, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_err    <= 1'b0;
            resp_shr    <= 1'b0;
            resp_rdata  <= '0;
            fault_pulse <= 1'b0;
            fault_addr  <= '0;
        end else begin
            resp_valid  <= accept;
            resp_err    <= accept && xn_fault;
            resp_shr    <= accept && hit_shr;
            resp_rdata  <= (accept && !is_wr && !xn_fault) ? bus_rdata : '0;
            fault_pulse <= accept && xn_fault;
            if (accept && xn_fault) begin
                fault_addr <= req_addr;
            end
        end
    end
endmodule

// File: rtl/mtob_checker.sv
// Protocol and ordering checks for mt_order_wbuf, attached by bind.
// Observes ports plus the classified type and the buffer fill level.
module mtob_checker
    import mtob_pkg::*;
#(
    parameter  int AW    = 16,
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic          req_fetch,
    input logic [AW-1:0] req_addr,
    input logic          resp_valid,
    input logic          resp_err,
    input logic          resp_shr,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic          fault_pulse,
    input logic [AW-1:0] fault_addr,
    input mem_type_e     hit_type,
    input logic          hit_xn,
    input logic [CW-1:0] fifo_fill,
    input logic          fifo_hit
);
    logic rd_req;
    logic xn_req;
    assign rd_req = !req_write || req_fetch;
    assign xn_req = req_fetch && hit_xn;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_fill <= CW'(DEPTH));

    assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rd_req && hit_type != MT_STRONG && fifo_fill == CW'(DEPTH))
        |-> !req_ready);

    assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    assert_strong_write_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !rd_req && hit_type == MT_STRONG)
        |-> (fifo_fill == '0 && bus_valid && bus_ready && bus_write && bus_addr == req_addr));

    assert_ordered_read_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && rd_req && !xn_req && hit_type != MT_NORMAL)
        |-> fifo_fill == '0);

    assert_same_addr_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_req && !xn_req && hit_type == MT_NORMAL && fifo_hit)
        |-> !req_ready);

    assert_xn_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xn_req)
        |=> (fault_pulse && resp_err && fault_addr == $past(req_addr)));

    assert_strong_shareable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit_type == MT_STRONG) |=> resp_shr);
endmodule

bind mt_order_wbuf mtob_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_fetch   (req_fetch),
    .req_addr    (req_addr),
    .resp_valid  (resp_valid),
    .resp_err    (resp_err),
    .resp_shr    (resp_shr),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .fault_pulse (fault_pulse),
    .fault_addr  (fault_addr),
    .hit_type    (hit_type),
    .hit_xn      (hit_xn),
    .fifo_fill   (fifo_fill),
    .fifo_hit    (fifo_hit)
);

// File: tb/sim_mt_order_wbuf.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps the whole 8-bit space for classification and
// walks the ordering cases with a stallable memory model on the bus.
module sim_mt_order_wbuf;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic [1:0]    cfg_type = '0;
    logic          cfg_shr = 1'b0;
    logic          cfg_xn = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_fetch = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          resp_valid, resp_err, resp_shr;
    logic [DW-1:0] resp_rdata;
    logic          bus_valid, bus_write, bus_shr;
    logic          bus_rdy = 1'b1;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          fault_pulse;
    logic [AW-1:0] fault_addr;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    mt_order_wbuf #(.AW(AW), .DW(DW), .NREG(8), .DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_type(cfg_type), .cfg_shr(cfg_shr),
        .cfg_xn(cfg_xn),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_shr(resp_shr),
        .resp_rdata(resp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_rdy), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_shr(bus_shr),
        .bus_rdata(bus_rdata),
        .fault_pulse(fault_pulse), .fault_addr(fault_addr)
    );

    // Bus memory model and transfer log.
    logic [DW-1:0] mem [256];
    logic [AW-1:0] log_addr [1024];
    logic [DW-1:0] log_data [1024];
    logic          log_wr   [1024];
    logic          log_shr  [1024];
    int            log_n;

    function automatic logic [DW-1:0] seed_val(input int a);
        return 32'h1000_0000 + a * 7;
    endfunction

    assign bus_rdata = mem[bus_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= seed_val(i);
            log_n <= 0;
        end else if (bus_valid && bus_rdy) begin
            if (bus_write) mem[bus_addr] <= bus_wdata;
            log_addr[log_n] <= bus_addr;
            log_data[log_n] <= bus_write ? bus_wdata : bus_rdata;
            log_wr[log_n]   <= bus_write;
            log_shr[log_n]  <= bus_shr;
            log_n           <= log_n + 1;
        end
    end

    // Bench copy of the region table.
    int tb_base [8];
    int tb_lim  [8];
    int tb_ty   [8];
    bit tb_sh   [8];
    bit tb_xn   [8];

    function automatic void exp_attr(input int a, output int t, output bit s, output bit x);
        t = 0; s = 1'b1; x = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (a >= tb_base[i] && a <= tb_lim[i]) begin
                t = tb_ty[i]; s = tb_sh[i]; x = tb_xn[i];
            end
        end
        if (t == 3) t = 2;
        if (t == 2) s = 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_region(input int i, input int b, input int l, input int t,
                              input bit s, input bit x);
        tb_base[i] = b; tb_lim[i] = l; tb_ty[i] = t; tb_sh[i] = s; tb_xn[i] = x;
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_base = AW'(b); cfg_limit = AW'(l);
        cfg_type = 2'(t); cfg_shr = s; cfg_xn = x;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_req(input bit w, input bit f, input int a, input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_fetch = f;
        req_addr = AW'(a); req_wdata = d;
    endtask

    task automatic finish_req(output logic [31:0] rd, output bit err, output bit shr,
                              output int waited);
        waited = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1; waited++;
        end
        @(negedge clk);
        chk(resp_valid == 1'b1, "R3", "response one cycle after acceptance", 32'(resp_valid), 1);
        rd = resp_rdata; err = resp_err; shr = resp_shr;
        req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
    endtask

    task automatic do_access(input bit w, input bit f, input int a, input logic [31:0] d,
                             output logic [31:0] rd, output bit err, output bit shr,
                             output int waited);
        start_req(w, f, a, d);
        finish_req(rd, err, shr, waited);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit err, shr, ex_s, ex_x;
        int waited, ex_t, base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: quiet outputs after reset.
        chk(resp_valid == 0, "R10", "resp_valid after reset", 32'(resp_valid), 0);
        chk(fault_pulse == 0, "R10", "fault_pulse after reset", 32'(fault_pulse), 0);
        chk(bus_valid == 0, "R10", "bus_valid after reset", 32'(bus_valid), 0);
        chk(fault_addr == 0, "R10", "fault_addr after reset", 32'(fault_addr), 0);

        // R1: empty table classifies everything Normal/shareable/executable.
        for (int i = 0; i < 8; i++) begin
            tb_base[i] = 255; tb_lim[i] = 0; tb_ty[i] = 0; tb_sh[i] = 0; tb_xn[i] = 0;
        end
        do_access(1'b0, 1'b1, 8'h47, '0, rd, err, shr, waited);
        chk(err == 0 && shr == 1, "R1", "unprogrammed table fetch", {30'd0, err, shr}, 32'd1);

        // Overlapping, empty and reserved-code regions.
        set_region(0, 8'h10, 8'h7F, 0, 1'b0, 1'b0);
        set_region(1, 8'h40, 8'h5F, 1, 1'b0, 1'b1);
        set_region(2, 8'h50, 8'h57, 2, 1'b0, 1'b0);
        set_region(3, 8'h80, 8'h9F, 3, 1'b0, 1'b1);
        set_region(4, 8'hA0, 8'hAF, 0, 1'b1, 1'b1);
        set_region(5, 8'hC0, 8'hBF, 1, 1'b0, 1'b1);
        set_region(6, 8'h60, 8'h6F, 1, 1'b1, 1'b0);
        set_region(7, 8'h18, 8'h1B, 0, 1'b0, 1'b1);

        // R1 R2 R9 R11: fetch sweep over the whole space.
        for (int a = 0; a < 256; a++) begin
            exp_attr(a, ex_t, ex_s, ex_x);
            base = log_n;
            do_access(1'b0, 1'b1, a, '0, rd, err, shr, waited);
            chk(err == ex_x, "R9", $sformatf("fetch error @%0h", a), 32'(err), 32'(ex_x));
            chk(fault_pulse == ex_x, "R9", $sformatf("fault pulse @%0h", a),
                32'(fault_pulse), 32'(ex_x));
            chk(shr == ex_s, "R2", $sformatf("resp_shr @%0h", a), 32'(shr), 32'(ex_s));
            if (ex_x) begin
                chk(fault_addr == AW'(a), "R9", "fault_addr", 32'(fault_addr), 32'(a));
                chk(log_n == base, "R9", "faulting fetch kept off bus", 32'(log_n), 32'(base));
            end else begin
                chk(rd == seed_val(a), "R11", $sformatf("fetch data @%0h", a), rd, seed_val(a));
                chk(log_shr[base] == ex_s, "R1", $sformatf("bus_shr @%0h", a),
                    32'(log_shr[base]), 32'(ex_s));
            end
        end

        // R9: the pulse lasts one cycle.
        do_access(1'b0, 1'b1, 8'h42, '0, rd, err, shr, waited);
        @(negedge clk);
        chk(fault_pulse == 0, "R9", "fault pulse single cycle", 32'(fault_pulse), 0);

        // R9: data reads of execute-never regions are normal.
        for (int a = 0; a < 256; a++) begin
            exp_attr(a, ex_t, ex_s, ex_x);
            do_access(1'b0, 1'b0, a, '0, rd, err, shr, waited);
            chk(err == 0 && fault_pulse == 0, "R9", $sformatf("data read no fault @%0h", a),
                {30'd0, err, fault_pulse}, 0);
            chk(rd == seed_val(a), "R11", $sformatf("read data @%0h", a), rd, seed_val(a));
        end

        // R3 R4: four posted writes with the bus stalled, then a fifth.
        bus_rdy = 1'b0;
        base = log_n;
        do_access(1'b1, 1'b0, 8'h20, 32'hAA00_0020, rd, err, shr, waited);
        chk(waited == 0, "R3", "post Normal write with bus stalled", 32'(waited), 0);
        do_access(1'b1, 1'b0, 8'h42, 32'hAA00_0042, rd, err, shr, waited);
        chk(waited == 0, "R3", "post Device write with bus stalled", 32'(waited), 0);
        do_access(1'b1, 1'b0, 8'h30, 32'hAA00_0030, rd, err, shr, waited);
        chk(waited == 0, "R3", "post third write", 32'(waited), 0);
        do_access(1'b1, 1'b0, 8'h61, 32'hAA00_0061, rd, err, shr, waited);
        chk(waited == 0, "R3", "post fourth write", 32'(waited), 0);
        start_req(1'b1, 1'b0, 8'h22, 32'hAA00_0022);
        #1;
        chk(req_ready == 0, "R3", "full buffer holds fifth write", 32'(req_ready), 0);
        @(negedge clk); #1;
        chk(req_ready == 0, "R3", "full buffer still holding", 32'(req_ready), 0);
        bus_rdy = 1'b1;
        finish_req(rd, err, shr, waited);
        repeat (8) @(negedge clk);
        chk(log_n == base + 5, "R4", "drained count", 32'(log_n - base), 5);
        chk(log_addr[base] == 8'h20 && log_addr[base+1] == 8'h42 &&
            log_addr[base+2] == 8'h30 && log_addr[base+3] == 8'h61 &&
            log_addr[base+4] == 8'h22, "R4", "drain order",
            {log_addr[base], log_addr[base+1], log_addr[base+2], log_addr[base+3]},
            32'h2042_3061);
        chk(log_data[base+1] == 32'hAA00_0042, "R4", "drained data",
            log_data[base+1], 32'hAA00_0042);
        chk(log_shr[base+1] == 0 && log_shr[base+3] == 1, "R4", "drained shareable",
            {30'd0, log_shr[base+1], log_shr[base+3]}, 1);

        // R5: Strongly-ordered write waits behind a buffered write.
        bus_rdy = 1'b0;
        base = log_n;
        do_access(1'b1, 1'b0, 8'h21, 32'hBB00_0021, rd, err, shr, waited);
        start_req(1'b1, 1'b0, 8'h52, 32'hBB00_0052);
        #1;
        chk(req_ready == 0, "R5", "SO write not buffered", 32'(req_ready), 0);
        @(negedge clk); @(negedge clk); #1;
        chk(req_ready == 0, "R5", "SO write still held", 32'(req_ready), 0);
        bus_rdy = 1'b1;
        finish_req(rd, err, shr, waited);
        repeat (3) @(negedge clk);
        chk(log_addr[base] == 8'h21 && log_addr[base+1] == 8'h52 && log_wr[base+1],
            "R5", "SO write after drain", {log_addr[base], log_addr[base+1]}, 16'h2152);
        chk(log_shr[base+1] == 1, "R2", "SO write shareable on bus",
            32'(log_shr[base+1]), 1);
        chk(shr == 1, "R2", "SO write shareable on response", 32'(shr), 1);

        // R5: SO write with empty buffer still waits for the bus.
        bus_rdy = 1'b0;
        base = log_n;
        start_req(1'b1, 1'b0, 8'h55, 32'hBB00_0055);
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 0, "R5", "SO write held until bus accepts", 32'(req_ready), 0);
        bus_rdy = 1'b1;
        finish_req(rd, err, shr, waited);
        chk(log_n == base + 1 && log_addr[base] == 8'h55, "R5", "SO write on bus",
            32'(log_addr[base]), 32'h55);

        // R6: Device read drains the buffer first.
        bus_rdy = 1'b0;
        base = log_n;
        do_access(1'b1, 1'b0, 8'h23, 32'hCC00_0023, rd, err, shr, waited);
        start_req(1'b0, 1'b0, 8'h62, '0);
        @(negedge clk);
        bus_rdy = 1'b1;
        finish_req(rd, err, shr, waited);
        chk(log_addr[base] == 8'h23 && log_addr[base+1] == 8'h62 && !log_wr[base+1],
            "R6", "Device read after drain", {log_addr[base], log_addr[base+1]}, 16'h2362);

        // R6: Strongly-ordered (reserved code) read drains first.
        bus_rdy = 1'b0;
        base = log_n;
        do_access(1'b1, 1'b0, 8'h27, 32'hCC00_0027, rd, err, shr, waited);
        start_req(1'b0, 1'b0, 8'h84, '0);
        @(negedge clk);
        bus_rdy = 1'b1;
        finish_req(rd, err, shr, waited);
        chk(log_addr[base] == 8'h27 && log_addr[base+1] == 8'h84, "R6",
            "SO read after drain", {log_addr[base], log_addr[base+1]}, 16'h2784);
        chk(shr == 1, "R2", "reserved code reads as SO, shareable", 32'(shr), 1);

        // R7: Normal read to another address bypasses the buffer.
        bus_rdy = 1'b0;
        base = log_n;
        do_access(1'b1, 1'b0, 8'h24, 32'hDD00_0024, rd, err, shr, waited);
        start_req(1'b0, 1'b0, 8'h25, '0);
        @(negedge clk);
        bus_rdy = 1'b1;
        finish_req(rd, err, shr, waited);
        repeat (2) @(negedge clk);
        chk(log_addr[base] == 8'h25 && !log_wr[base] && log_addr[base+1] == 8'h24,
            "R7", "Normal read bypasses", {log_addr[base], log_addr[base+1]}, 16'h2524);
        chk(rd == seed_val(8'h25), "R7", "bypass read data", rd, seed_val(8'h25));

        // R8: Normal read to a buffered address waits and sees new data.
        bus_rdy = 1'b0;
        base = log_n;
        do_access(1'b1, 1'b0, 8'h26, 32'hCAFE_0026, rd, err, shr, waited);
        start_req(1'b0, 1'b0, 8'h26, '0);
        @(negedge clk);
        bus_rdy = 1'b1;
        finish_req(rd, err, shr, waited);
        chk(log_addr[base] == 8'h26 && log_wr[base] && !log_wr[base+1], "R8",
            "same-address read after write", {31'd0, log_wr[base+1]}, 0);
        chk(rd == 32'hCAFE_0026, "R8", "read returns newest data", rd, 32'hCAFE_0026);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule